// File: doc/BRIEF.md
# Two-Level Local-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It looks up the branch's own recent outcome pattern in a first-level table of per-branch shift registers. That pattern is then combined with branch address bits to pick a 2-bit saturating counter in a second-level table. The counter's upper half means "taken". The fetch side presents a branch address on the lookup port and gets a registered prediction one cycle later. The execute side presents each resolved branch on the update port. An update trains the counter chosen by the history that held before that update, then ages the branch's history by one outcome.

Each counter is a four-state machine. The states are STRONG_NT (0), WEAK_NT (1), WEAK_T (2) and STRONG_T (3). A taken outcome moves a counter one state toward STRONG_T: STRONG_NT→WEAK_NT, WEAK_NT→WEAK_T, WEAK_T→STRONG_T, and STRONG_T stays at STRONG_T. A not-taken outcome moves it one state back toward STRONG_NT, and STRONG_NT stays at STRONG_NT. The WEAK_T and STRONG_T states predict taken.

Table sizes are parameters. The default is 64 histories of 10 bits, selected by address bits [7:2], and 1024 counters. A second setting uses 256 histories of 12 bits and 4096 counters. A parameter switches the second-level index from "address XOR history" to "history alone", which gives the wide-history setting (14-bit history, 16K counters).

Top module: `lhp_predictor`

## Requirements
- R1: After reset every history entry is all zeros and every counter is in WEAK_NT (1). `pred_valid` is low, and any lookup made before the first update predicts not taken.
- R2: The cycle after `lk_valid` is high, `pred_valid` is high and `pred_taken` is high exactly when the selected counter is WEAK_T or STRONG_T. The cycle after `lk_valid` is low, both `pred_valid` and `pred_taken` are low.
- R3: A counter saturates. A taken update moves it up by one but never above 3, and a not-taken update moves it down by one but never below 0.
- R4: In the default hashed mode, the counter index is `pc[HIST_W+1:2] XOR history`. An update trains the counter at the index formed with that branch's history as it was before the update.
- R5: An update shifts the branch's history entry left by one. The resolved outcome (1 = taken) enters at bit 0, and the oldest bit is dropped.
- R6: The history entry is selected by `pc[L1_IDX_W+1:2]`. Branches that agree in those bits share one history entry, even when they differ in higher address bits.
- R7: A lookup in the same cycle as an update sees the tables as they were before that update.
- R8: A cycle with `upd_valid` low changes no history and no counter, whatever `upd_pc` and `upd_taken` carry.
- R9: With `USE_PC_HASH` = 0, the counter index is the selected history alone. Branches whose histories are equal then share a counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | PC_W | Address of the branch to predict |
| upd_valid | input | 1 | Resolved branch presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| pred_valid | output | 1 | Prediction present, one cycle after a lookup |
| pred_taken | output | 1 | Predicted direction, 1 = taken |

## Verification
On every cycle, the assertions check three things. The prediction valid flag follows the lookup strobe by exactly one cycle. Each update moves the trained counter by at most one step, in the direction of the outcome, and only stops at the ends. The written history entry holds its old lower bits moved up by one place, with the outcome at bit 0.

Some behaviour only the bench's scenarios can show. These are: training at the pre-update history index, sharing of history between aliasing addresses, the ordering of a lookup against an update in the same cycle, learning of a periodic loop pattern, the direct-index variant, and the fact that an invalid update leaves the tables alone. The bench shows these against its own reference model of the tables.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

    typedef enum logic [1:0] {
        STRONG_NT = 2'd0,
        WEAK_NT   = 2'd1,
        WEAK_T    = 2'd2,
        STRONG_T  = 2'd3
    } ctr_state_e;

    // saturating transition of one direction counter
    function automatic ctr_state_e ctr_next(input ctr_state_e cur, input logic taken);
        ctr_state_e nxt;
        unique case (cur)
            STRONG_NT: nxt = taken ? WEAK_NT  : STRONG_NT;
            WEAK_NT:   nxt = taken ? WEAK_T   : STRONG_NT;
            WEAK_T:    nxt = taken ? STRONG_T : WEAK_NT;
            STRONG_T:  nxt = taken ? STRONG_T : WEAK_T;
            default:   nxt = WEAK_NT;
        endcase
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr_state_e cur);
        logic t;
        unique case (cur)
            WEAK_T, STRONG_T:   t = 1'b1;
            STRONG_NT, WEAK_NT: t = 1'b0;
            default:            t = 1'b0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/lhp_hist_table.sv
module lhp_hist_table #(
    parameter int IDX_W  = 6,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_bit,
    output logic [HIST_W-1:0] wr_old
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] hist_q [DEPTH];

    assign rd_hist = hist_q[rd_idx];
    assign wr_old  = hist_q[wr_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                hist_q[i] <= '0;
            end
        end else if (wr_en) begin
            hist_q[wr_idx] <= {wr_old[HIST_W-2:0], wr_bit};
        end
    end

    AST_HIST_NEWEST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hist_q[$past(wr_idx)][0] == $past(wr_bit)); // R5
    AST_HIST_AGES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hist_q[$past(wr_idx)][HIST_W-1:1] == $past(wr_old[HIST_W-2:0])); // R5

endmodule

// File: rtl/lhp_index.sv
module lhp_index #(
    parameter int IDX_W       = 10,
    parameter bit USE_PC_HASH = 1'b1
) (
    input  logic [IDX_W-1:0] pc_bits,
    input  logic [IDX_W-1:0] hist,
    output logic [IDX_W-1:0] idx
);
    generate
        if (USE_PC_HASH) begin : g_hash
            assign idx = pc_bits ^ hist;
        end else begin : g_direct
            logic [IDX_W-1:0] pc_unused;
            assign pc_unused = pc_bits;
            assign idx = hist | (pc_unused & '0);
        end
    endgenerate
endmodule

// File: rtl/lhp_ctr_table.sv
module lhp_ctr_table
    import lhp_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_state_e       rd_state,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_state_e ctr_q [DEPTH];
    ctr_state_e upd_old;

    assign rd_state = ctr_q[rd_idx];
    assign upd_old  = ctr_q[upd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ctr_q[i] <= WEAK_NT;
            end
        end else if (upd_en) begin
            ctr_q[upd_idx] <= ctr_next(upd_old, upd_taken);
        end
    end

    AST_CTR_NO_DROP_ON_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_taken) |=> ctr_q[$past(upd_idx)] >= $past(upd_old)); // R3
    AST_CTR_NO_RISE_ON_NT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_taken) |=> ctr_q[$past(upd_idx)] <= $past(upd_old)); // R3
    AST_CTR_MOVES_UNLESS_END: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !(upd_taken && upd_old == STRONG_T) && !(!upd_taken && upd_old == STRONG_NT))
        |=> ctr_q[$past(upd_idx)] != $past(upd_old)); // R3

endmodule

// File: rtl/lhp_predictor.sv
module lhp_predictor
    import lhp_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int ALIGN_W     = 2,
    parameter int L1_IDX_W    = 6,
    parameter int HIST_W      = 10,
    parameter bit USE_PC_HASH = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    output logic            pred_valid,
    output logic            pred_taken
);
    localparam int PHT_IDX_W = HIST_W;

    logic [HIST_W-1:0]    lk_hist;
    logic [HIST_W-1:0]    up_hist;
    logic [PHT_IDX_W-1:0] lk_idx;
    logic [PHT_IDX_W-1:0] up_idx;
    ctr_state_e           lk_state;

    lhp_hist_table #(.IDX_W(L1_IDX_W), .HIST_W(HIST_W)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (lk_pc[ALIGN_W +: L1_IDX_W]),
        .rd_hist (lk_hist),
        .wr_en   (upd_valid),
        .wr_idx  (upd_pc[ALIGN_W +: L1_IDX_W]),
        .wr_bit  (upd_taken),
        .wr_old  (up_hist)
    );

    lhp_index #(.IDX_W(PHT_IDX_W), .USE_PC_HASH(USE_PC_HASH)) u_lk_index (
        .pc_bits (lk_pc[ALIGN_W +: PHT_IDX_W]),
        .hist    (lk_hist),
        .idx     (lk_idx)
    );

    lhp_index #(.IDX_W(PHT_IDX_W), .USE_PC_HASH(USE_PC_HASH)) u_up_index (
        .pc_bits (upd_pc[ALIGN_W +: PHT_IDX_W]),
        .hist    (up_hist),
        .idx     (up_idx)
    );

    lhp_ctr_table #(.IDX_W(PHT_IDX_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (lk_idx),
        .rd_state  (lk_state),
        .upd_en    (upd_valid),
        .upd_idx   (up_idx),
        .upd_taken (upd_taken)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid <= 1'b0;
            pred_taken <= 1'b0;
        end else begin
            pred_valid <= lk_valid;
            pred_taken <= lk_valid & ctr_says_taken(lk_state);
        end
    end

    AST_PRED_FOLLOWS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> pred_valid); // R2
    AST_PRED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!pred_valid && !pred_taken)); // R2

endmodule

// File: tb/tb_lhp_predictor.sv
`timescale 1ns/1ps
module tb_lhp_predictor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic        pred_valid, pred_taken;
    logic        dpred_valid, dpred_taken;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference tables, hashed default (R4) and direct variant (R9)
    logic [9:0] m_hist [64];
    logic [1:0] m_cnt  [1024];
    logic [3:0] d_hist [8];
    logic [1:0] d_cnt  [16];

    always #5 clk = ~clk;

    lhp_predictor dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .pred_valid(pred_valid), .pred_taken(pred_taken)
    );

    lhp_predictor #(.L1_IDX_W(3), .HIST_W(4), .USE_PC_HASH(1'b0)) dut_dir (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .pred_valid(dpred_valid), .pred_taken(dpred_taken)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
        if (t) return (c == 2'd3) ? 2'd3 : c + 2'd1;
        return (c == 2'd0) ? 2'd0 : c - 2'd1;
    endfunction

    function automatic logic m_pred(input logic [31:0] pc);
        return m_cnt[pc[11:2] ^ m_hist[pc[7:2]]] >= 2'd2;
    endfunction

    function automatic logic d_pred(input logic [31:0] pc);
        return d_cnt[d_hist[pc[4:2]]] >= 2'd2;
    endfunction

    task automatic model_update(input logic [31:0] pc, input logic t);
        logic [9:0] h;
        logic [3:0] dh;
        h  = m_hist[pc[7:2]];
        m_cnt[pc[11:2] ^ h] = sat(m_cnt[pc[11:2] ^ h], t);
        m_hist[pc[7:2]] = {h[8:0], t};
        dh = d_hist[pc[4:2]];
        d_cnt[dh] = sat(d_cnt[dh], t);
        d_hist[pc[4:2]] = {dh[2:0], t};
    endtask

    // lookup; returns the default instance's prediction
    task automatic do_lookup(input logic [31:0] pc, input string req, output logic got);
        logic em, ed;
        @(negedge clk);
        lk_valid = 1'b1;
        lk_pc    = pc;
        em = m_pred(pc);
        ed = d_pred(pc);
        @(negedge clk);
        lk_valid = 1'b0;
        check({req, " valid"}, pred_valid, 1);
        check({req, " hashed"}, pred_taken, em);
        check({req, " R9 direct"}, dpred_taken, ed);
        got = pred_taken;
    endtask

    task automatic do_update(input logic [31:0] pc, input logic t);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc    = pc;
        upd_taken = t;
        model_update(pc, t);
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic g;
        check("R1 pred_valid in reset", pred_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pred_valid after reset", pred_valid, 0);
        check("R1 pred_taken after reset", pred_taken, 0);
        do_lookup(32'h0000_0000, "R1", g);
        check("R1 not taken", g, 0);
        do_lookup(32'h0000_0ABC, "R1", g);
        check("R1 not taken", g, 0);
        do_lookup(32'hFFFF_FFFC, "R1", g);
        check("R1 not taken", g, 0);
    endtask

    task automatic t_idle;
        logic g;
        do_lookup(32'h0000_0010, "R2", g);
        @(negedge clk);
        check("R2 valid drops when idle", pred_valid, 0);
        check("R2 taken low when idle", pred_taken, 0);
    endtask

    task automatic t_old_history;
        logic g;
        do_update(32'h0000_0100, 1'b1);
        do_lookup(32'h0000_0100, "R5 shifted history", g);
        check("R5 new history picks fresh counter", g, 0);
        do_update(32'h0000_0100, 1'b1);
        do_lookup(32'h0000_0104, "R4 old-history index", g);
        check("R4 counter at pc^old history trained", g, 1);
    endtask

    task automatic t_shared_history;
        logic g;
        do_update(32'h0000_0208, 1'b1);
        do_update(32'h0000_0208, 1'b1);
        do_update(32'h0000_0308, 1'b0);
        do_lookup(32'h0000_0308, "R6 shared entry", g);
        do_lookup(32'h0000_0208, "R6 shared entry", g);
        do_lookup(32'h0000_1208, "R6 high pc bits ignored", g);
    endtask

    task automatic t_saturation;
        logic g;
        for (int i = 0; i < 15; i++) do_update(32'h0000_00F0, 1'b1);
        do_update(32'h0000_0F0C, 1'b0);
        do_lookup(32'h0000_0F0C, "R3 upper saturation", g);
        check("R3 held at 3 then one step down", g, 1);
        for (int i = 0; i < 4; i++) do_update(32'h0000_0F0C, 1'b0);
        do_lookup(32'h0000_00F0, "R3 lower saturation", g);
        check("R3 floor at 0", g, 0);
        do_update(32'h0000_0F0C, 1'b1);
        do_lookup(32'h0000_00F0, "R3 one step from floor", g);
        check("R3 0 -> 1 still not taken", g, 0);
    endtask

    task automatic t_loop_pattern;
        logic g;
        for (int i = 0; i < 40; i++) do_update(32'h0000_04A0, (i % 4) != 3);
        for (int i = 40; i < 48; i++) begin
            do_lookup(32'h0000_04A0, "R4 R5 loop", g);
            check("R5 periodic pattern learned", g, int'((i % 4) != 3));
            do_update(32'h0000_04A0, (i % 4) != 3);
        end
    endtask

    task automatic t_collision;
        logic em, ed;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            lk_valid = 1'b1;  lk_pc  = 32'h0000_0100;
            upd_valid = 1'b1; upd_pc = 32'h0000_0100; upd_taken = 1'b0;
            em = m_pred(32'h0000_0100);
            ed = d_pred(32'h0000_0100);
            model_update(32'h0000_0100, 1'b0);
            @(negedge clk);
            lk_valid = 1'b0; upd_valid = 1'b0;
            check("R7 lookup sees pre-update", pred_taken, em);
            check("R7 R9 direct pre-update", dpred_taken, ed);
        end
    endtask

    task automatic t_ignored_update;
        logic g;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            upd_valid = 1'b0;
            upd_pc    = 32'h0000_04A0;
            upd_taken = k[0];
        end
        do_lookup(32'h0000_04A0, "R8 invalid update ignored", g);
        check("R8 loop pattern intact", g, 1);
        do_lookup(32'h0000_0104, "R8 invalid update ignored", g);
    endtask

    task automatic t_direct;
        logic g;
        for (int k = 0; k < 3; k++) do_update(32'h0000_0018, 1'b1);
        do_lookup(32'h0000_0018, "R9 direct train", g);
        do_lookup(32'h0000_001C, "R9 direct other entry", g);
    endtask

    initial begin
        for (int i = 0; i < 64; i++)   m_hist[i] = '0;
        for (int i = 0; i < 1024; i++) m_cnt[i]  = 2'd1;
        for (int i = 0; i < 8; i++)    d_hist[i] = '0;
        for (int i = 0; i < 16; i++)   d_cnt[i]  = 2'd1;
        repeat (3) @(negedge clk);
        t_reset();
        t_idle();
        t_old_history();
        t_shared_history();
        t_saturation();
        t_loop_pattern();
        t_collision();
        t_ignored_update();
        t_direct();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule